// File: doc/BRIEF.md
# General-Purpose Pin Register Bank

This block holds the control and status bytes for a bank of general-purpose pins split into byte-wide ports. Each port has four byte registers: a read-only view of the pins, an output latch, a polarity mask applied to that pin view, and a direction mask. A bus front end reaches all of them through a small register interface: a register index, a write strobe, write data and combinational read data.

Pin levels come in asynchronously. They pass through a multi-stage synchroniser before they are read. Outputs leave as a level and an enable per pin. Register writes do not reach the pins directly. The output latch and the direction mask are copied into a drive stage only when the front end pulses the commit strobe. This lets the front end pick the exact cycle in which the pins change.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every direction bit is 1 (all pins inputs, `pin_oe` all 0), every output latch bit is 1, every polarity bit is 0, and the synchronised pin view is 0.
- R2: Index bits [2:1] select the register kind: 0 pin view, 1 output latch, 2 polarity, 3 direction. Index bit [0] selects the port, with 0 covering pins 7:0 and 1 covering pins 15:8. Index 6 is the direction byte of port 0 and index 7 is the direction byte of port 1.
- R3: A write to index 2 through 7 replaces only the addressed byte, from the next cycle on. Every other byte keeps its value.
- R4: A write to index 0 or 1 changes no register and no pin output.
- R5: Reading an output latch index returns the stored byte, whatever the pin levels are.
- R6: Reading a pin-view index returns the pin byte sampled two clock edges earlier, XORed bit by bit with that port's polarity byte.
- R7: After a commit, `pin_oe` bit n is 1 exactly when direction bit n is 0.
- R8: Where a pin is an input, `pin_out` is 0. Where a pin is an output, `pin_out` carries the committed output latch bit.
- R9: `pin_out` and `pin_oe` change only in the cycle after `commit` is high. They then take the latch and direction values held before that edge, so a write in the same cycle as the commit is not included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Driven pin levels |
| pin_oe | output | 16 | Per-pin output enable, 1 drives |
| reg_idx | input | 3 | Register index |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_idx` |
| commit | input | 1 | Copies the output latch and direction bytes to the pins |

## Verification
The bench builds the block with its default values: two byte-wide ports and a two-stage synchroniser. With these values all eight indices can be reached, and the two-edge input latency can be predicted exactly. Directed and random traffic mixes the following cases: writes to the ignored pin-view indices, commits in the same cycle as a latch write, mixed-direction bytes, and polarity masks. A behavioural model is compared with every output on every cycle.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   typedef enum logic [1:0] {
      KIND_PIN = 2'd0,
      KIND_OUT = 2'd1,
      KIND_POL = 2'd2,
      KIND_DIR = 2'd3
   } reg_kind_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_in,
   output logic [W-1:0] sync_out
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stage_q [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
      end else begin
         stage_q[0] <= async_in;
         for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
      end
   end

   assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] wdata,
   input  logic         we_out,
   input  logic         we_pol,
   input  logic         we_dir,
   input  logic         commit,
   output logic [W-1:0] out_q,
   output logic [W-1:0] pol_q,
   output logic [W-1:0] dir_q,
   output logic [W-1:0] drv_level,
   output logic [W-1:0] drv_oe
);
   logic [W-1:0] drv_out_q;
   logic [W-1:0] drv_dir_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_q     <= '1;
         pol_q     <= '0;
         dir_q     <= '1;
         drv_out_q <= '1;
         drv_dir_q <= '1;
      end else begin
         if (commit) begin
            drv_out_q <= out_q;
            drv_dir_q <= dir_q;
         end
         if (we_out) out_q <= wdata;
         if (we_pol) pol_q <= wdata;
         if (we_dir) dir_q <= wdata;
      end
   end

   assign drv_oe    = ~drv_dir_q;
   assign drv_level = drv_out_q & ~drv_dir_q;

   // R3
   out_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we_out |=> out_q == $past(wdata));
   // R3
   dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we_dir |=> dir_q == $past(wdata));
   // R7
   oe_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> drv_oe == ~$past(dir_q));
   // R9
   drive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> ($stable(drv_level) && $stable(drv_oe)));
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
   import gpio_bank_pkg::*;
#(
   parameter int W      = 8,
   parameter int NPORTS = 2,
   parameter int PSEL_W = 1
) (
   input  logic [PSEL_W+1:0]          idx,
   input  logic [NPORTS-1:0][W-1:0]   pin_view,
   input  logic [NPORTS-1:0][W-1:0]   out_bytes,
   input  logic [NPORTS-1:0][W-1:0]   pol_bytes,
   input  logic [NPORTS-1:0][W-1:0]   dir_bytes,
   output logic [W-1:0]               rdata
);
   reg_kind_e         kind;
   logic [PSEL_W-1:0] psel;

   assign kind = reg_kind_e'(idx[PSEL_W+1:PSEL_W]);
   assign psel = idx[PSEL_W-1:0];

   always_comb begin
      unique case (kind)
         KIND_PIN: rdata = pin_view[psel] ^ pol_bytes[psel];
         KIND_OUT: rdata = out_bytes[psel];
         KIND_POL: rdata = pol_bytes[psel];
         KIND_DIR: rdata = dir_bytes[psel];
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
   import gpio_bank_pkg::*;
#(
   parameter int NPORTS      = 2,
   parameter int PORT_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NPORTS*PORT_W-1:0]   pin_in,
   output logic [NPORTS*PORT_W-1:0]   pin_out,
   output logic [NPORTS*PORT_W-1:0]   pin_oe,
   input  logic [$clog2(NPORTS)+1:0]  reg_idx,
   input  logic                       reg_we,
   input  logic [PORT_W-1:0]          reg_wdata,
   output logic [PORT_W-1:0]          reg_rdata,
   input  logic                       commit
);
   localparam int PINS   = NPORTS * PORT_W;
   localparam int PSEL_W = $clog2(NPORTS);

   if (NPORTS < 2 || (NPORTS & (NPORTS - 1)) != 0) begin : g_bad_ports
      $error("gpio_bank: NPORTS must be a power of two, at least 2");
   end
   if (PORT_W < 1) begin : g_bad_width
      $error("gpio_bank: PORT_W must be positive");
   end

   reg_kind_e                      wr_kind;
   logic [PSEL_W-1:0]              wr_port;
   logic [PINS-1:0]                pin_sync;
   logic [NPORTS-1:0][PORT_W-1:0]  pin_view, out_b, pol_b, dir_b, lvl_b, oe_b;

   assign wr_kind  = reg_kind_e'(reg_idx[PSEL_W+1:PSEL_W]);
   assign wr_port  = reg_idx[PSEL_W-1:0];
   assign pin_view = pin_sync;

   gpio_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pin_in),
      .sync_out (pin_sync)
   );

   for (genvar p = 0; p < NPORTS; p++) begin : g_port
      logic hit;
      assign hit = reg_we && (wr_port == PSEL_W'(p));

      gpio_port_regs #(.W(PORT_W)) u_regs (
         .clk       (clk),
         .rst_n     (rst_n),
         .wdata     (reg_wdata),
         .we_out    (hit && wr_kind == KIND_OUT),
         .we_pol    (hit && wr_kind == KIND_POL),
         .we_dir    (hit && wr_kind == KIND_DIR),
         .commit    (commit),
         .out_q     (out_b[p]),
         .pol_q     (pol_b[p]),
         .dir_q     (dir_b[p]),
         .drv_level (lvl_b[p]),
         .drv_oe    (oe_b[p])
      );
   end

   assign pin_out = lvl_b;
   assign pin_oe  = oe_b;

   gpio_read_mux #(.W(PORT_W), .NPORTS(NPORTS), .PSEL_W(PSEL_W)) u_rmux (
      .idx       (reg_idx),
      .pin_view  (pin_view),
      .out_bytes (out_b),
      .pol_bytes (pol_b),
      .dir_bytes (dir_b),
      .rdata     (reg_rdata)
   );

   // R4
   pin_view_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && wr_kind == KIND_PIN) |=> ($stable(out_b) && $stable(pol_b) && $stable(dir_b)));
   // R8
   input_pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_out & ~pin_oe) == '0);
endmodule

// File: tb/gpio_bank_bench.sv
module gpio_bank_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] pin_in = '0;
   logic [15:0] pin_out, pin_oe;
   logic [2:0]  reg_idx = '0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        commit = 1'b0;

   int checks = 0;
   int errors = 0;
   bit started = 1'b0;

   always #5 clk = ~clk;

   gpio_bank u_gpio_bank (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
      .reg_idx(reg_idx), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .commit(commit)
   );

   // Behavioural model
   logic [15:0] m_out = 16'hFFFF, m_pol = '0, m_dir = 16'hFFFF;
   logic [15:0] m_dout = 16'hFFFF, m_ddir = 16'hFFFF;
   logic [15:0] hist[$];

   always @(posedge clk) begin
      started = 1'b1;
      if (!rst_n) begin
         m_out = 16'hFFFF; m_pol = '0; m_dir = 16'hFFFF;
         m_dout = 16'hFFFF; m_ddir = 16'hFFFF;
         hist.delete();
      end else begin
         if (commit) begin m_dout = m_out; m_ddir = m_dir; end
         if (reg_we) begin
            case (reg_idx[2:1])
               2'd1: if (reg_idx[0]) m_out[15:8] = reg_wdata; else m_out[7:0] = reg_wdata;
               2'd2: if (reg_idx[0]) m_pol[15:8] = reg_wdata; else m_pol[7:0] = reg_wdata;
               2'd3: if (reg_idx[0]) m_dir[15:8] = reg_wdata; else m_dir[7:0] = reg_wdata;
               default: ;
            endcase
         end
         hist.push_back(pin_in);
         if (hist.size() > 2) void'(hist.pop_front());
      end
   end

   task automatic check(string req, logic [15:0] got, logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
      end
   endtask

   function automatic logic [7:0] pick(logic [15:0] v, logic hi);
      return hi ? v[15:8] : v[7:0];
   endfunction

   always @(negedge clk) begin
      if (started) begin
         logic [15:0] sy;
         logic [7:0]  exp;
         string       tag;
         sy = (hist.size() == 2) ? hist[0] : 16'h0;
         case (reg_idx[2:1])
            2'd0: begin exp = pick(sy ^ m_pol, reg_idx[0]); tag = "R6"; end
            2'd1: begin exp = pick(m_out, reg_idx[0]);      tag = "R5"; end
            2'd2: begin exp = pick(m_pol, reg_idx[0]);      tag = "R3"; end
            default: begin exp = pick(m_dir, reg_idx[0]);   tag = "R2"; end
         endcase
         if (!rst_n) tag = "R1";
         check(tag, {8'h0, reg_rdata}, {8'h0, exp});
         check(rst_n ? "R8" : "R1", pin_out, m_dout & ~m_ddir);
         check(rst_n ? "R7" : "R1", pin_oe, ~m_ddir);
      end
   end

   task automatic step(logic [2:0] idx, logic we, logic [7:0] wd, logic cm, logic [15:0] pins);
      @(posedge clk); #2;
      reg_idx = idx; reg_we = we; reg_wdata = wd; commit = cm; pin_in = pins;
   endtask

   task automatic finish_run();
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (2000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      // R1 reset values read through the register port
      step(3'd6, 0, 0, 0, 16'h1234);
      #1 check("R1", {8'h0, reg_rdata}, 16'h00FF);
      step(3'd3, 0, 0, 0, 16'h1234);
      #1 check("R1", {8'h0, reg_rdata}, 16'h00FF);
      check("R1", pin_oe, 16'h0000);
      rst_n = 1'b1;
      // R2 direction bytes at 6 and 7, R3 latch writes
      step(3'd6, 1, 8'h00, 0, 16'h1234);
      step(3'd7, 1, 8'hF0, 0, 16'h1234);
      step(3'd2, 1, 8'hA5, 0, 16'h1234);
      step(3'd3, 1, 8'h3C, 0, 16'h1234);
      step(3'd7, 0, 0, 0, 16'h1234);
      #1 check("R2", {8'h0, reg_rdata}, 16'h00F0);
      check("R9", pin_oe, 16'h0000);
      step(3'd3, 0, 0, 1, 16'h1234);
      step(3'd3, 0, 0, 0, 16'h1234);
      #1 check("R7", pin_oe, 16'h0FFF);
      check("R8", pin_out, 16'h0CA5);
      check("R5", {8'h0, reg_rdata}, 16'h003C);
      // R6 polarity and synchroniser latency
      step(3'd4, 1, 8'hFF, 0, 16'h00C3);
      step(3'd0, 0, 0, 0, 16'h00C3);
      step(3'd0, 0, 0, 0, 16'h00C3);
      #1 check("R6", {8'h0, reg_rdata}, 16'h003C);
      // R4 writes to pin-view indices are ignored
      step(3'd0, 1, 8'h55, 0, 16'h00C3);
      step(3'd1, 1, 8'h66, 0, 16'h00C3);
      step(3'd2, 0, 0, 1, 16'h00C3);
      step(3'd2, 0, 0, 0, 16'h00C3);
      #1 check("R4", {8'h0, reg_rdata}, 16'h00A5);
      check("R4", pin_out, 16'h0CA5);
      // R9 commit in same cycle as write excludes that write
      step(3'd2, 1, 8'h0F, 1, 16'h00C3);
      step(3'd2, 0, 0, 0, 16'h00C3);
      #1 check("R9", pin_out, 16'h0CA5);
      check("R3", {8'h0, reg_rdata}, 16'h000F);
      // random traffic
      for (int i = 0; i < 600; i++)
         step(3'($urandom), 1'($urandom), 8'($urandom), ($urandom % 4) == 0, 16'($urandom));
      step(3'd0, 0, 0, 0, 16'h0);
      @(posedge clk); #2;
      finish_run();
   end
endmodule